// File: doc/BRIEF.md
# Bidirectional Shift-and-Hold Row Driver Core

This block is the digital core of a display row driver with a parameterized channel count, 40 by default. Serial row data is clocked into a shift register that can move either way. A direction select decides which of two serial ports takes data in and which sends it out. Because the ports swap roles with direction, several cores can be chained in either orientation.

A level-sensitive hold stage sits behind the shift register, under the control of a strobe. While the strobe is low the channel outputs follow the register. While it is high they keep the image captured at the rising edge of the strobe. An output stage can force all channels to a blank level and can invert every channel. A clear input that is active low and asynchronous empties the shift register at any time.

The shift clock is an ordinary input sampled by the system clock `clk`. A shift happens on each detected rising edge of that input. `rst_n` is a synchronous reset, active low.

Top module: `rowdrv_core`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, the shift register and the shift-clock edge detector clear. With strobe, blank and polarity low, every `drv_out` bit then reads 0.
- R2: With `dir_right` = 1, a detected rising edge of `shift_clk` shifts stage k into stage k+1. Stage 0 (bit 0) takes the inverse of `a_in`. The new contents are visible after that `clk` edge.
- R3: With `dir_right` = 0, a detected rising edge of `shift_clk` shifts stage k+1 into stage k. The last stage (bit CHANNELS-1) takes the inverse of `b_in`.
- R4: Without a new rising edge of `shift_clk`, the register holds its contents, even while `shift_clk` stays high over many `clk` cycles.
- R5: `b_out` always carries the inverse of the last stage. `a_out` always carries the inverse of stage 0.
- R6: `b_oe` equals `dir_right` and `a_oe` equals its inverse, so exactly one port drives at any time. A direction change affects the next shift.
- R7: A low `clear_n` forces every shift register bit to 0 at once, without waiting for `clk`. It does not touch the hold stage while the strobe is high.
- R8: While `strobe` is low, the hold stage passes the shift register contents straight through.
- R9: While `strobe` is high, the hold stage keeps the value it had just before the strobe rose.
- R10: With `blank` low, `drv_out[i]` equals hold bit i when `polarity` is 0 and its inverse when `polarity` is 1.
- R11: With `blank` high, every `drv_out` bit is 1 when `polarity` is 0 and 0 when `polarity` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the shift clock |
| rst_n | input | 1 | Synchronous reset, active low |
| shift_clk | input | 1 | Shift clock; each rising edge shifts once |
| dir_right | input | 1 | 1: A in, B out, toward higher stages; 0: the reverse |
| a_in | input | 1 | Serial port A input side |
| a_out | output | 1 | Serial port A output side (inverse of stage 0) |
| a_oe | output | 1 | Port A drive enable |
| b_in | input | 1 | Serial port B input side |
| b_out | output | 1 | Serial port B output side (inverse of last stage) |
| b_oe | output | 1 | Port B drive enable |
| clear_n | input | 1 | Asynchronous register clear, active low |
| strobe | input | 1 | Hold control: low passes, high holds |
| blank | input | 1 | Forces all channels to the blank level |
| polarity | input | 1 | Inverts channel outputs and the blank level |
| drv_out | output | CHANNELS | Channel outputs |

## Verification
The assertions assume that `shift_clk` is low while `rst_n` is low, so that the edge detector and the previous sampled value agree after reset. They also assume that any low pulse on `clear_n` spans at least one rising edge of `clk`, which keeps the register-hold property from seeing an unsampled clear. The stimulus changes inputs only just after a rising edge of `clk`. It holds `shift_clk` low through reset and keeps `clear_n` low for two full cycles whenever it clears. It also holds strobe, blank and polarity steady on every cycle where the hold property is expected to apply.

// File: rtl/rowdrv_pkg.sv
// Shared types and helpers for the row driver core.
package rowdrv_pkg;

    // Shift direction, encoded to match the dir_right pin.
    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } shift_dir_e;

    // Serial port roles chosen by the direction.
    typedef struct packed {
        logic a_drives;
        logic b_drives;
    } port_role_t;

    // Decode of the direction into port drive enables.
    function automatic port_role_t role_of(input shift_dir_e dir);
        port_role_t r;
        r.a_drives = (dir == DIR_LEFT);
        r.b_drives = (dir == DIR_RIGHT);
        return r;
    endfunction

endpackage

// File: rtl/rowdrv_edge.sv
// Rising-edge detector for the shift clock.
// Assumes level_in is synchronous to clk. Produces a one-cycle pulse in the
// clk cycle where level_in is first seen high.
module rowdrv_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise_out
);
    logic level_d;

    // Remember the previous sample of the level.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level_in;
    end

    assign rise_out = level_in & ~level_d;
endmodule

// File: rtl/rowdrv_shifter.sv
// Bidirectional shift register with inverted serial entry.
// Right: stage 0 takes ~right_in, stage k+1 takes stage k.
// Left: the last stage takes ~left_in, stage k takes stage k+1.
// Clear is asynchronous and active low. The reset is synchronous.
module rowdrv_shifter
    import rowdrv_pkg::*;
#(
    parameter int WIDTH = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_n,
    input  logic             shift_en,
    input  shift_dir_e       dir,
    input  logic             right_in,
    input  logic             left_in,
    output logic [WIDTH-1:0] stages
);
    localparam int LAST = WIDTH - 1;

    logic [WIDTH-1:0] next_stages;

    // Per-stage next value chosen by the direction.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic from_low;
        logic from_high;
        if (i == 0) begin : g_first
            assign from_low = ~right_in;
        end else begin : g_mid_low
            assign from_low = stages[i-1];
        end
        if (i == LAST) begin : g_last
            assign from_high = ~left_in;
        end else begin : g_mid_high
            assign from_high = stages[i+1];
        end
        assign next_stages[i] = (dir == DIR_RIGHT) ? from_low : from_high;
    end

    // Register update: async clear, sync reset, shift on enable.
    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n)     stages <= '0;
        else if (!rst_n)  stages <= '0;
        else if (shift_en) stages <= next_stages;
    end
endmodule

// File: rtl/rowdrv_hold.sv
// Level-sensitive hold stage. It is transparent while strobe is low and
// keeps its last value while strobe is high.
module rowdrv_hold #(
    parameter int WIDTH = 40
) (
    input  logic             strobe,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    // Pass when strobe is low, keep otherwise.
    always_latch begin
        if (!strobe) q_out <= d_in;
    end
endmodule

// File: rtl/rowdrv_outstage.sv
// Channel output stage: polarity inversion and blanking.
// Blank forces the level ~polarity. Otherwise each channel is held ^ polarity.
module rowdrv_outstage #(
    parameter int WIDTH = 40
) (
    input  logic             blank,
    input  logic             polarity,
    input  logic [WIDTH-1:0] held,
    output logic [WIDTH-1:0] drive
);
    // One output cell per channel.
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        assign drive[i] = blank ? ~polarity : (held[i] ^ polarity);
    end
endmodule

// File: rtl/rowdrv_core.sv
// Top of the row driver core: edge detector, shift register, hold stage and
// output stage. The serial port roles follow dir_right. The shift clock is
// sampled by clk, and inputs are assumed synchronous to clk.
module rowdrv_core
    import rowdrv_pkg::*;
#(
    parameter int CHANNELS = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_clk,
    input  logic                dir_right,
    input  logic                a_in,
    output logic                a_out,
    output logic                a_oe,
    input  logic                b_in,
    output logic                b_out,
    output logic                b_oe,
    input  logic                clear_n,
    input  logic                strobe,
    input  logic                blank,
    input  logic                polarity,
    output logic [CHANNELS-1:0] drv_out
);
    localparam int LAST = CHANNELS - 1;

    shift_dir_e          dir;
    port_role_t          role;
    logic                shift_pulse;
    logic [CHANNELS-1:0] sr_q;
    logic [CHANNELS-1:0] held_q;

    assign dir  = shift_dir_e'(dir_right);
    assign role = role_of(dir);

    rowdrv_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (shift_clk),
        .rise_out (shift_pulse)
    );

    rowdrv_shifter #(.WIDTH(CHANNELS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_n  (clear_n),
        .shift_en (shift_pulse),
        .dir      (dir),
        .right_in (a_in),
        .left_in  (b_in),
        .stages   (sr_q)
    );

    rowdrv_hold #(.WIDTH(CHANNELS)) u_hold (
        .strobe (strobe),
        .d_in   (sr_q),
        .q_out  (held_q)
    );

    rowdrv_outstage #(.WIDTH(CHANNELS)) u_out (
        .blank    (blank),
        .polarity (polarity),
        .held     (held_q),
        .drive    (drv_out)
    );

    // Serial outputs carry the inverted end stages; enables decode direction.
    assign a_out = ~sr_q[0];
    assign b_out = ~sr_q[LAST];
    assign a_oe  = role.a_drives;
    assign b_oe  = role.b_drives;
endmodule

// File: rtl/rowdrv_core_chk.sv
// Property checker for rowdrv_core, attached by bind.
// Assumes shift_clk is low during reset and that clear pulses span a clk edge.
module rowdrv_core_chk #(
    parameter int CHANNELS = 40
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clear_n,
    input logic                shift_clk,
    input logic                dir_right,
    input logic                a_in,
    input logic                b_in,
    input logic                strobe,
    input logic                blank,
    input logic                polarity,
    input logic                a_oe,
    input logic                b_oe,
    input logic [CHANNELS-1:0] drv_out,
    input logic [CHANNELS-1:0] sr_bits
);
    localparam int LAST = CHANNELS - 1;

    // R6: exactly one port drives, and B drives when shifting right
    a_r6_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe != b_oe) && (b_oe == dir_right));

    // R2: a right shift moves data up and enters ~a_in at stage 0
    a_r2_right_shift: assert property (@(posedge clk) disable iff (!rst_n || !clear_n)
        (shift_clk && !$past(shift_clk) && dir_right) |=>
        (sr_bits[0] == ~$past(a_in)) && (sr_bits[LAST:1] == $past(sr_bits[LAST-1:0])));

    // R3: a left shift moves data down and enters ~b_in at the last stage
    a_r3_left_shift: assert property (@(posedge clk) disable iff (!rst_n || !clear_n)
        (shift_clk && !$past(shift_clk) && !dir_right) |=>
        (sr_bits[LAST] == ~$past(b_in)) && (sr_bits[LAST-1:0] == $past(sr_bits[LAST:1])));

    // R4: no shift-clock rise means the register holds
    a_r4_hold_no_edge: assert property (@(posedge clk) disable iff (!rst_n || !clear_n)
        (shift_clk && $past(shift_clk)) || !shift_clk |=> $stable(sr_bits));

    // R7: while clear is low the register is empty
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n |-> (sr_bits == '0));

    // R9: a held strobe with steady output controls keeps the outputs frozen
    a_r9_strobe_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && $past(strobe) && $stable(blank) && $stable(polarity)) |-> $stable(drv_out));
endmodule

bind rowdrv_core rowdrv_core_chk #(.CHANNELS(CHANNELS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_n   (clear_n),
    .shift_clk (shift_clk),
    .dir_right (dir_right),
    .a_in      (a_in),
    .b_in      (b_in),
    .strobe    (strobe),
    .blank     (blank),
    .polarity  (polarity),
    .a_oe      (a_oe),
    .b_oe      (b_oe),
    .drv_out   (drv_out),
    .sr_bits   (sr_q)
);

// File: tb/test_rowdrv_core.sv
// Scoreboard bench for rowdrv_core. Driver tasks update a requirement-level
// model and queue expected outputs. A monitor compares them at the falling edge.
module test_rowdrv_core;
    localparam int W = 40;
    localparam int LIMIT = 200000;

    typedef struct {
        logic [W-1:0] drv;
        logic         b_drives;
        logic         ser;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shift_clk = 1'b0;
    logic         dir_right = 1'b1;
    logic         a_in = 1'b0;
    logic         b_in = 1'b0;
    logic         clear_n = 1'b1;
    logic         strobe = 1'b0;
    logic         blank = 1'b0;
    logic         polarity = 1'b0;
    logic         a_out, a_oe, b_out, b_oe;
    logic [W-1:0] drv_out;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    exp_t sb[$];

    logic [W-1:0] m_sr = '0;
    logic [W-1:0] m_lat = '0;

    rowdrv_core #(.CHANNELS(W)) i_rowdrv_core (
        .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .dir_right(dir_right),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .clear_n(clear_n), .strobe(strobe), .blank(blank), .polarity(polarity),
        .drv_out(drv_out)
    );

    always #5 clk = ~clk;

    // Queue the expected outputs for the current inputs, then move to the next cycle.
    task automatic expect_now(input string tag);
        exp_t e;
        if (!strobe) m_lat = m_sr;
        e.drv      = blank ? {W{~polarity}} : (m_lat ^ {W{polarity}});
        e.b_drives = dir_right;
        e.ser      = dir_right ? ~m_sr[W-1] : ~m_sr[0];
        e.tag      = tag;
        sb.push_back(e);
        @(posedge clk); #1;
    endtask

    // One serial bit: raise shift_clk, let the edge land, drop it again.
    task automatic shift_one(input logic dir, input logic din, input string tag);
        dir_right = dir;
        if (dir) a_in = din; else b_in = din;
        shift_clk = 1'b1;
        @(posedge clk); #1;
        if (dir) m_sr = {m_sr[W-2:0], ~din};
        else     m_sr = {~din, m_sr[W-1:1]};
        shift_clk = 1'b0;
        expect_now(tag);
    endtask

    // Monitor: compare each queued item at the falling edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            logic act_ser;
            e = sb.pop_front();
            vectors++;
            act_ser = b_oe ? b_out : a_out;
            if (drv_out !== e.drv || b_oe !== e.b_drives || a_oe !== ~e.b_drives
                || act_ser !== e.ser) begin
                fails++;
                $display("FAIL %s: drv_out=%h b_oe=%b a_oe=%b ser=%b expected drv_out=%h b_oe=%b a_oe=%b ser=%b",
                         e.tag, drv_out, b_oe, a_oe, act_ser, e.drv, e.b_drives, ~e.b_drives, e.ser);
            end
        end
    end

    // Watchdog: an expired run counts as a failure.
    initial begin
        #(LIMIT * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        // R1: synchronous reset clears register; outputs read zero
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        m_sr  = '0;
        expect_now("R1 reset state");

        // R2 / R5 / R6: right shift of a patterned word, watching b_out
        for (int i = 0; i < W; i++) shift_one(1'b1, (i % 3) == 0, "R2 right shift");
        for (int i = 0; i < 5; i++) shift_one(1'b1, 1'b1, "R5 serial out right");

        // R4: hold without new edges, and with shift_clk held high
        expect_now("R4 idle hold");
        shift_clk = 1'b1; a_in = 1'b1;
        @(posedge clk); #1;
        m_sr = {m_sr[W-2:0], 1'b0};
        for (int i = 0; i < 4; i++) expect_now("R4 level held high");
        shift_clk = 1'b0;
        expect_now("R4 release");

        // R9: strobe high freezes outputs while shifting left
        strobe = 1'b1;
        expect_now("R9 strobe rise");
        for (int i = 0; i < 10; i++) shift_one(1'b0, (i % 2) == 0, "R9 hold while shifting");
        // R8: dropping strobe shows current register
        strobe = 1'b0;
        expect_now("R8 transparent");
        // R3 / R6: left shifts with transparent hold, watching a_out
        for (int i = 0; i < 12; i++) shift_one(1'b0, (i % 4) < 2, "R3 left shift");

        // R10 / R11: all four blank/polarity combinations
        polarity = 1'b1; expect_now("R10 polarity inverts");
        polarity = 1'b0; expect_now("R10 polarity plain");
        blank = 1'b1;    expect_now("R11 blank high level");
        polarity = 1'b1; expect_now("R11 blank low level");
        blank = 1'b0; polarity = 1'b0;
        expect_now("R10 back to data");

        // R7: clear in the middle of right shifting, hold transparent
        for (int i = 0; i < 6; i++) shift_one(1'b1, 1'b0, "R2 before clear");
        clear_n = 1'b0; m_sr = '0;
        expect_now("R7 clear empties register");
        expect_now("R7 clear held");
        clear_n = 1'b1;
        expect_now("R7 after clear");

        // R7 / R9: clear with strobe high leaves the hold stage untouched
        for (int i = 0; i < 8; i++) shift_one(1'b1, 1'b0, "R2 refill");
        strobe = 1'b1;
        expect_now("R9 capture");
        clear_n = 1'b0; m_sr = '0;
        expect_now("R7 clear spares held image");
        expect_now("R7 clear spares held image 2");
        clear_n = 1'b1;
        strobe = 1'b0;
        expect_now("R8 shows cleared register");

        // R6: direction swap takes effect on the next shift
        shift_one(1'b0, 1'b0, "R6 swap to left");
        shift_one(1'b1, 1'b0, "R6 swap to right");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule